// File: doc/BRIEF.md
# Ring Buffer DMA Address Wrapper

This block manages the destination address on the write side of a DMA channel. Each burst of 128-bit quadwords goes to memory at the current destination address. The address then moves forward by 16 bytes per quadword. When ring steering is active, the address is folded back into a memory ring. The ring is described by a byte base address and a byte mask: a folded address equals the base plus the masked address. The mask is expected to have the form 2^k−16, and the base is expected to be aligned to the ring size.

Steering is selected with a two-bit mode:

| Mode value | Meaning |
|---|---|
| 0 | Off |
| 1 | Ring mode, consumer A |
| 2 | Ring mode, consumer B |
| 3 | Reserved |

In ring mode, a burst whose start address lies outside the ring still writes. It raises a one-cycle warning and is left out of the transferred-quadword tally. When the channel step ends with a non-zero tally, three things happen together:

- the address is folded again;
- the tally is offered to the selected consumer on a valid/count handshake that holds until that consumer is ready;
- the tally is cleared.

In off and reserved modes the address simply grows linearly.

Top module: `ring_dma_wrap`

## Requirements
- R1: After reset the destination address is 0, the warning output is low, both consumer valids are low and the internal tally is zero.
- R2: In ring mode (cfg_mode 1 or 2), a burst of N quadwords from address A sets the address in the next cycle to ring_base + ((A + 16·N) & ring_mask).
- R3: In ring mode, a burst whose start address satisfies (A & ~ring_mask) != ring_base raises ring_warn for the following cycle only. The write is still issued and the address still advances and folds as in R2.
- R4: Only ring-mode bursts that start inside the ring add their N to the tally. Out-of-ring bursts add nothing.
- R5: In modes 0 and 3 a burst advances the address by exactly 16·N with no folding. It never raises ring_warn and never changes the tally.
- R6: Step end has two outcomes in ring mode when no handoff is pending:
  - with a non-zero tally, the cycle after step_end folds the address once more, presents the tally on cons_count and clears the tally;
  - with a zero tally, step_end has no effect.
- R7: A handoff raises only one valid: bit 0 of cons_valid for mode 1, bit 1 for mode 2. The valid and cons_count stay unchanged until the matching cons_ready bit is high at a clock edge, after which the valid drops.
- R8: While a handoff is pending, step_end starts no new handoff and the tally is kept for a later step end.
- R9: addr_load replaces the destination address with addr_load_val in the next cycle. It takes priority over a burst in the same cycle, and that burst does not move the address and does not add to the tally.
- R10: The memory write port mirrors the burst in the same cycle in every mode: mem_wr_en equals burst_valid, mem_wr_addr equals the current destination address, and mem_wr_qwc equals burst_qwc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | 0 off, 1 ring to consumer A, 2 ring to consumer B, 3 reserved |
| ring_base | input | 32 | Ring base byte address |
| ring_mask | input | 32 | Ring byte mask, 2^k−16 |
| addr_load | input | 1 | Load a new destination address |
| addr_load_val | input | 32 | Address to load |
| burst_valid | input | 1 | A burst is issued this cycle |
| burst_qwc | input | 16 | Quadwords in the burst |
| step_end | input | 1 | The channel step ends this cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 32 | Memory write start address |
| mem_wr_qwc | output | 16 | Memory write length in quadwords |
| dst_addr | output | 32 | Current destination address |
| ring_warn | output | 1 | Previous burst started outside the ring |
| cons_valid | output | 2 | Handoff valid, one bit per consumer |
| cons_ready | input | 2 | Consumer ready, one bit per consumer |
| cons_count | output | 32 | Quadword count being handed off |

## Verification
Bursts are run in four patterns, each aimed at one way the address logic could go wrong:

- in-ring bursts that cross the ring's top edge, which show the fold and the tally;
- a burst that starts at an address outside the ring, which separates "warn but write" from "block" and from "count anyway";
- the same bursts in off and reserved modes, which show linear growth and prove that no tally builds up;
- a load that coincides with a burst, which shows the load's priority.

Handoffs are checked three ways: held against a stalled consumer, requested again while one is pending, and started after loading an out-of-ring address. Together these show that the tally survives, that the second fold takes place, and that each mode reaches its own consumer.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
    parameter int ADDR_W = 32;

    typedef enum logic [1:0] {
        STEER_OFF  = 2'd0,
        STEER_TO_A = 2'd1,
        STEER_TO_B = 2'd2,
        STEER_RSVD = 2'd3
    } steer_mode_e;

    // Fold an address into the ring described by base and mask.
    function automatic logic [ADDR_W-1:0] ring_fold(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] base,
        input logic [ADDR_W-1:0] mask
    );
        return base + (a & mask);
    endfunction
endpackage

// File: rtl/ring_dma_addr_step.sv
module ring_dma_addr_step
    import ring_dma_pkg::*;
#(
    parameter int QWC_W = 16
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [QWC_W-1:0]  qwc,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    input  logic              ring_en,
    output logic              in_ring,
    output logic [ADDR_W-1:0] next_addr
);
    localparam int STEP_W = QWC_W + 4;

    logic [STEP_W-1:0] step_bytes;
    logic [ADDR_W-1:0] linear;

    always_comb begin
        step_bytes = {qwc, 4'b0000};
        linear     = cur_addr + ADDR_W'(step_bytes);
        in_ring    = ((cur_addr & ~mask) == base);
        next_addr  = ring_en ? ring_fold(linear, base, mask) : linear;
    end
endmodule

// File: rtl/ring_dma_handoff.sv
module ring_dma_handoff #(
    parameter int NUM_CONS = 2,
    parameter int CNT_W    = 32,
    localparam int SEL_W   = (NUM_CONS > 1) ? $clog2(NUM_CONS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic [SEL_W-1:0]    launch_sel,
    input  logic [CNT_W-1:0]    launch_cnt,
    input  logic [NUM_CONS-1:0] ready,
    output logic [NUM_CONS-1:0] valid,
    output logic [CNT_W-1:0]    count,
    output logic                busy
);
    typedef struct packed {
        logic             pend;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
    } hs_t;

    hs_t hs_d, hs_q;

    always_comb begin
        hs_d = hs_q;
        if (hs_q.pend && ready[hs_q.sel]) begin
            hs_d.pend = 1'b0;
        end
        if (launch && !hs_q.pend) begin
            hs_d.pend = 1'b1;
            hs_d.sel  = launch_sel;
            hs_d.cnt  = launch_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= '0;
        end else begin
            hs_q <= hs_d;
        end
    end

    for (genvar gi = 0; gi < NUM_CONS; gi++) begin : g_valid
        assign valid[gi] = hs_q.pend && (hs_q.sel == SEL_W'(gi));
    end

    assign count = hs_q.cnt;
    assign busy  = hs_q.pend;
endmodule

// File: rtl/ring_dma_wrap.sv
module ring_dma_wrap
    import ring_dma_pkg::*;
#(
    parameter int QWC_W = 16,
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [ADDR_W-1:0] ring_mask,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_load_val,
    input  logic              burst_valid,
    input  logic [QWC_W-1:0]  burst_qwc,
    input  logic              step_end,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [QWC_W-1:0]  mem_wr_qwc,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              ring_warn,
    output logic [1:0]        cons_valid,
    input  logic [1:0]        cons_ready,
    output logic [CNT_W-1:0]  cons_count
);
    localparam int NUM_CONS = 2;
    localparam int SEL_W    = $clog2(NUM_CONS);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  tally;
        logic              warn;
    } wr_state_t;

    wr_state_t   st_d, st_q;
    steer_mode_e mode;
    logic        ring_en;
    logic        in_ring;
    logic [ADDR_W-1:0] stepped;
    logic        hs_busy;
    logic        launch;
    logic [SEL_W-1:0] launch_sel;
    logic [CNT_W-1:0] tally_now;

    assign mode    = steer_mode_e'(cfg_mode);
    assign ring_en = (mode == STEER_TO_A) || (mode == STEER_TO_B);

    ring_dma_addr_step #(.QWC_W(QWC_W)) u_step (
        .cur_addr (st_q.addr),
        .qwc      (burst_qwc),
        .base     (ring_base),
        .mask     (ring_mask),
        .ring_en  (ring_en),
        .in_ring  (in_ring),
        .next_addr(stepped)
    );

    always_comb begin
        st_d      = st_q;
        st_d.warn = 1'b0;
        if (addr_load) begin
            st_d.addr = addr_load_val;
        end else if (burst_valid) begin
            st_d.addr = stepped;
            if (ring_en) begin
                if (in_ring) begin
                    st_d.tally = st_q.tally + CNT_W'(burst_qwc);
                end else begin
                    st_d.warn = 1'b1;
                end
            end
        end
        tally_now  = st_d.tally;
        launch     = step_end && ring_en && (tally_now != '0) && !hs_busy;
        launch_sel = (mode == STEER_TO_B) ? SEL_W'(1) : SEL_W'(0);
        if (launch) begin
            st_d.addr  = ring_fold(st_d.addr, ring_base, ring_mask);
            st_d.tally = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    ring_dma_handoff #(.NUM_CONS(NUM_CONS), .CNT_W(CNT_W)) u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .launch_sel(launch_sel),
        .launch_cnt(tally_now),
        .ready     (cons_ready),
        .valid     (cons_valid),
        .count     (cons_count),
        .busy      (hs_busy)
    );

    assign mem_wr_en   = burst_valid;
    assign mem_wr_addr = st_q.addr;
    assign mem_wr_qwc  = burst_qwc;
    assign dst_addr    = st_q.addr;
    assign ring_warn   = st_q.warn;
endmodule

// File: rtl/ring_dma_wrap_chk.sv
module ring_dma_wrap_chk
    import ring_dma_pkg::*;
#(
    parameter int QWC_W = 16,
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_mode,
    input logic              addr_load,
    input logic [ADDR_W-1:0] addr_load_val,
    input logic              burst_valid,
    input logic [QWC_W-1:0]  burst_qwc,
    input logic              step_end,
    input logic [ADDR_W-1:0] dst_addr,
    input logic              ring_warn,
    input logic [1:0]        cons_valid,
    input logic [1:0]        cons_ready,
    input logic [CNT_W-1:0]  cons_count
);
    logic linear_mode;
    assign linear_mode = (cfg_mode == 2'd0) || (cfg_mode == 2'd3);

    p_warn_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ring_warn |-> ($past(burst_valid) && !$past(addr_load)
                       && ($past(cfg_mode) == 2'd1 || $past(cfg_mode) == 2'd2)));

    p_linear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_valid && !addr_load && linear_mode)
        |=> (dst_addr == $past(dst_addr) + ADDR_W'({$past(burst_qwc), 4'b0000})) && !ring_warn);

    p_one_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cons_valid));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cons_valid & ~cons_ready) != 2'b00) |=> ($stable(cons_valid) && $stable(cons_count)));

    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_load && !step_end) |=> (dst_addr == $past(addr_load_val)));
endmodule

bind ring_dma_wrap ring_dma_wrap_chk #(.QWC_W(QWC_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_mode     (cfg_mode),
    .addr_load    (addr_load),
    .addr_load_val(addr_load_val),
    .burst_valid  (burst_valid),
    .burst_qwc    (burst_qwc),
    .step_end     (step_end),
    .dst_addr     (dst_addr),
    .ring_warn    (ring_warn),
    .cons_valid   (cons_valid),
    .cons_ready   (cons_ready),
    .cons_count   (cons_count)
);

// File: tb/ring_dma_wrap_test.sv
`timescale 1ns/1ps
module ring_dma_wrap_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [31:0] ring_base = 32'h0001_0000;
    logic [31:0] ring_mask = 32'h0000_00F0;
    logic        addr_load = 1'b0;
    logic [31:0] addr_load_val = '0;
    logic        burst_valid = 1'b0;
    logic [15:0] burst_qwc = '0;
    logic        step_end = 1'b0;
    logic        mem_wr_en;
    logic [31:0] mem_wr_addr;
    logic [15:0] mem_wr_qwc;
    logic [31:0] dst_addr;
    logic        ring_warn;
    logic [1:0]  cons_valid;
    logic [1:0]  cons_ready = 2'b00;
    logic [31:0] cons_count;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    ring_dma_wrap uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .ring_base(ring_base), .ring_mask(ring_mask),
        .addr_load(addr_load), .addr_load_val(addr_load_val),
        .burst_valid(burst_valid), .burst_qwc(burst_qwc),
        .step_end(step_end),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_qwc(mem_wr_qwc),
        .dst_addr(dst_addr), .ring_warn(ring_warn),
        .cons_valid(cons_valid), .cons_ready(cons_ready), .cons_count(cons_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic burst(input logic [15:0] n);
        burst_valid = 1'b1;
        burst_qwc   = n;
        cyc();
        burst_valid = 1'b0;
    endtask

    task automatic load(input logic [31:0] a);
        addr_load     = 1'b1;
        addr_load_val = a;
        cyc();
        addr_load = 1'b0;
    endtask

    task automatic step();
        step_end = 1'b1;
        cyc();
        step_end = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) cyc();
        chk("R1 addr", dst_addr, 32'h0);
        chk("R1 warn", {31'b0, ring_warn}, 32'h0);
        chk("R1 valid", {30'b0, cons_valid}, 32'h0);
        rst_n = 1'b1;
        cyc();
    endtask

    task automatic t_ring_bursts();
        cfg_mode = 2'd1;
        load(32'h0001_00E0);
        burst_valid = 1'b1;
        burst_qwc   = 16'd3;
        #1;
        chk("R10 wr_en", {31'b0, mem_wr_en}, 32'h1);
        chk("R10 wr_addr", mem_wr_addr, 32'h0001_00E0);
        chk("R10 wr_qwc", {16'b0, mem_wr_qwc}, 32'h3);
        cyc();
        burst_valid = 1'b0;
        chk("R2 fold across top", dst_addr, 32'h0001_0010);
        chk("R2 no warn in ring", {31'b0, ring_warn}, 32'h0);
        burst(16'd2);
        chk("R2 second burst", dst_addr, 32'h0001_0030);
    endtask

    task automatic t_out_of_ring();
        load(32'h0002_0040);
        burst_valid = 1'b1;
        burst_qwc   = 16'd1;
        #1;
        chk("R3 write still issued", {31'b0, mem_wr_en}, 32'h1);
        cyc();
        burst_valid = 1'b0;
        chk("R3 warn raised", {31'b0, ring_warn}, 32'h1);
        chk("R3 addr folded", dst_addr, 32'h0001_0050);
        cyc();
        chk("R3 warn one cycle", {31'b0, ring_warn}, 32'h0);
    endtask

    task automatic t_handoff();
        step();
        chk("R6 valid to A", {30'b0, cons_valid}, 32'h1);
        chk("R4 only in-ring counted", cons_count, 32'd5);
        chk("R6 addr after step", dst_addr, 32'h0001_0050);
        cyc();
        cyc();
        chk("R7 held valid", {30'b0, cons_valid}, 32'h1);
        chk("R7 held count", cons_count, 32'd5);
        burst(16'd1);
        step();
        chk("R8 no relaunch", {30'b0, cons_valid}, 32'h1);
        chk("R8 count unchanged", cons_count, 32'd5);
        cons_ready = 2'b01;
        cyc();
        cons_ready = 2'b00;
        chk("R7 drop on ready", {30'b0, cons_valid}, 32'h0);
        step();
        chk("R8 kept tally delivered", cons_count, 32'd1);
        chk("R8 valid again", {30'b0, cons_valid}, 32'h1);
        cons_ready = 2'b01;
        cyc();
        cons_ready = 2'b00;
    endtask

    task automatic t_rewrap_b();
        cfg_mode = 2'd2;
        burst(16'd2);
        chk("R2 mode B fold", dst_addr, 32'h0001_0080);
        load(32'h0003_0020);
        step();
        chk("R6 refold on step", dst_addr, 32'h0001_0020);
        chk("R7 valid to B", {30'b0, cons_valid}, 32'h2);
        chk("R6 count B", cons_count, 32'd2);
        cons_ready = 2'b01;
        cyc();
        chk("R7 wrong ready ignored", {30'b0, cons_valid}, 32'h2);
        cons_ready = 2'b10;
        cyc();
        cons_ready = 2'b00;
        chk("R7 B released", {30'b0, cons_valid}, 32'h0);
    endtask

    task automatic t_idle_step();
        step();
        chk("R6 zero tally no handoff", {30'b0, cons_valid}, 32'h0);
        chk("R6 zero tally addr kept", dst_addr, 32'h0001_0020);
    endtask

    task automatic t_linear_modes();
        cfg_mode = 2'd0;
        load(32'h0001_00F0);
        burst(16'd2);
        chk("R5 off linear", dst_addr, 32'h0001_0110);
        chk("R5 off no warn", {31'b0, ring_warn}, 32'h0);
        cfg_mode = 2'd3;
        burst(16'd1);
        chk("R5 reserved linear", dst_addr, 32'h0001_0120);
        cfg_mode = 2'd1;
        step();
        chk("R5 no tally built", {30'b0, cons_valid}, 32'h0);
    endtask

    task automatic t_load_priority();
        load(32'h0001_0000);
        addr_load     = 1'b1;
        addr_load_val = 32'h0001_0080;
        burst_valid   = 1'b1;
        burst_qwc     = 16'd3;
        cyc();
        addr_load   = 1'b0;
        burst_valid = 1'b0;
        chk("R9 load wins", dst_addr, 32'h0001_0080);
        step();
        chk("R9 burst not counted", {30'b0, cons_valid}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_ring_bursts();
        t_out_of_ring();
        t_handoff();
        t_rewrap_b();
        t_idle_step();
        t_linear_modes();
        t_load_priority();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule